// File: doc/BRIEF.md
# Floating-Point Error Dispatch Gate

This block sits in the issue path of a processor's floating-point unit and decides what happens to each floating-point instruction offered to it. It can issue the instruction, turn it into a numeric exception request, or hold it back. The choice rests on three things. The first is an internal error-pending flag, which an error-detected pulse sets. The second is a numeric-error mode bit. The third is an active-low external ignore-error pin, which may change at any time relative to the core clock.

Instructions arrive on a valid/ready interface together with a decoded class. The source keeps `ins_valid` high, with the same class, until `ins_ready` is seen high at a rising edge. `ins_ready` rises in two cases: the instruction is granted, or it is replaced by an exception request. While the instruction is held back, `stall` is high and `ins_ready` is low. The source must wait, and may not withdraw the instruction or change its class.

Control instructions are exempt from any hold-back. A subset of them clears the pending error. An active-low error output mirrors the pending flag so that external logic can raise an interrupt.

Top module: `fp_err_gate`

## Requirements
- R1: After reset no error is pending: `err_n` is 1, `stall` is 0, and with `ins_valid` low, `issue_grant`, `exc_req` and `ins_ready` are 0.
- R2: A cycle with `err_det` high makes `err_n` 0 from the next cycle on, and it stays 0 until a clearing instruction is accepted.
- R3: With `mode_exc` = 1 and an error pending, a valid non-control instruction (class 2'b00 or 2'b11) raises `exc_req` with `exc_vector` = 16 in the same cycle. It also drives `ins_ready` = 1 with `issue_grant` = 0, and the error stays pending. `exc_vector` is 0 whenever `exc_req` is 0.
- R4: With `mode_exc` = 0 and the synchronised `ignore_n` at 0, a pending error is ignored and non-control instructions are granted.
- R5: With `mode_exc` = 0, an error pending and the synchronised `ignore_n` at 1, a valid non-control instruction gets `stall` = 1 and `ins_ready` = 0. It is granted in the cycle after the second rising edge that samples `ignore_n` = 0, because the pin passes through a two-flop synchroniser.
- R6: Control instructions (class 2'b01 keep-error and 2'b10 clear-error) are always granted, whatever the mode, pin or pending state.
- R7: An accepted class 2'b10 instruction clears the pending error, so `err_n` is 1 from the next cycle on. A class 2'b01 instruction leaves the pending state unchanged.
- R8: When `err_det` is high in the same cycle as an accepted class 2'b10 instruction, the error remains pending.
- R9: `issue_grant`, `stall` and `exc_req` are never high together, and none of them is high without `ins_valid`. `ins_ready` equals `issue_grant` OR `exc_req`.
- R10: With no error pending, every valid instruction of any class is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_class | input | 2 | 00 non-control, 01 control keeping error, 10 control clearing error, 11 non-control |
| ins_ready | output | 1 | Instruction consumed this cycle |
| err_det | input | 1 | Unmasked numeric error detected (pulse) |
| mode_exc | input | 1 | 1: pending errors raise an exception; 0: gating by the ignore pin |
| ignore_n | input | 1 | Asynchronous active-low ignore-error pin |
| issue_grant | output | 1 | Instruction issued |
| stall | output | 1 | Instruction frozen |
| exc_req | output | 1 | Numeric exception requested instead of issue |
| exc_vector | output | 8 | Exception vector number (16 when requested) |
| err_n | output | 1 | Active-low error output, low while an error is pending |

## Verification
The hardest case to reach is a frozen instruction being released. This needs mode 0, a pending error, the ignore pin high, and a non-control instruction held on the interface across several cycles. The pin must then fall while the instruction is still held. The stimulus builds this state in that order and keeps the instruction valid while the pin change travels through the synchroniser. The per-cycle reference model then pins down the exact release cycle. A long mixed phase follows, with random classes, pulses, mode and pin changes, and it reaches the exception and clear-versus-new-error collisions many times.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [1:0] {
    FC_ARITH = 2'b00,
    FC_KEEP  = 2'b01,
    FC_CLEAR = 2'b10,
    FC_OTHER = 2'b11
  } fp_class_e;

  function automatic logic is_exempt(input logic [1:0] cls);
    return (cls == FC_KEEP) || (cls == FC_CLEAR);
  endfunction

  function automatic logic is_clearing(input logic [1:0] cls);
    return cls == FC_CLEAR;
  endfunction
endpackage

// File: rtl/fpg_sync.sv
module fpg_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fpg_pend.sv
module fpg_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;   // a new error beats a clear
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/fpg_decide.sv
module fpg_decide
  import fpg_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int EXC_VECTOR = 16
) (
  input  logic             valid_i,
  input  logic [1:0]       cls_i,
  input  logic             pend_i,
  input  logic             mode_i,
  input  logic             ign_n_sync_i,
  output logic             grant_o,
  output logic             stall_o,
  output logic             exc_o,
  output logic [VEC_W-1:0] vec_o
);
  logic hit;

  always_comb begin
    hit     = valid_i && pend_i && !is_exempt(cls_i);
    exc_o   = hit && mode_i;
    stall_o = hit && !mode_i && ign_n_sync_i;
    grant_o = valid_i && !exc_o && !stall_o;
    vec_o   = exc_o ? VEC_W'(EXC_VECTOR) : '0;
  end
endmodule

// File: rtl/fp_err_gate.sv
module fp_err_gate
  import fpg_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int EXC_VECTOR  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [1:0]       ins_class,
  output logic             ins_ready,
  input  logic             err_det,
  input  logic             mode_exc,
  input  logic             ignore_n,
  output logic             issue_grant,
  output logic             stall,
  output logic             exc_req,
  output logic [VEC_W-1:0] exc_vector,
  output logic             err_n
);
  logic ign_n_s;
  logic pend;
  logic clr;

  fpg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ignore_n), .q_sync(ign_n_s)
  );

  // clearing class is exempt, so it is always accepted when valid
  assign clr = ins_valid && is_clearing(ins_class);

  fpg_pend u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(err_det), .clr_i(clr), .pend_o(pend)
  );

  fpg_decide #(.VEC_W(VEC_W), .EXC_VECTOR(EXC_VECTOR)) u_dec (
    .valid_i(ins_valid), .cls_i(ins_class), .pend_i(pend),
    .mode_i(mode_exc), .ign_n_sync_i(ign_n_s),
    .grant_o(issue_grant), .stall_o(stall), .exc_o(exc_req), .vec_o(exc_vector)
  );

  assign ins_ready = issue_grant || exc_req;
  assign err_n     = !pend;
endmodule

// File: rtl/fp_err_gate_chk.sv
module fp_err_gate_chk #(
  parameter int VEC_W      = 8,
  parameter int EXC_VECTOR = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic [1:0]       ins_class,
  input logic             ins_ready,
  input logic             err_det,
  input logic             mode_exc,
  input logic             issue_grant,
  input logic             stall,
  input logic             exc_req,
  input logic [VEC_W-1:0] exc_vector,
  input logic             err_n
);
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({issue_grant, stall, exc_req}) <= 1);

  a_r9_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant || stall || exc_req) |-> ins_valid);

  a_r2_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    err_det |=> !err_n);

  a_r3_vector: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_vector == VEC_W'(EXC_VECTOR) && mode_exc && !err_n));

  a_r6_control_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_class inside {2'b01, 2'b10}) |-> issue_grant);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_class == 2'b10 && !err_det) |=> err_n);

  a_r10_free_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && err_n) |-> (issue_grant && ins_ready));
endmodule

bind fp_err_gate fp_err_gate_chk #(.VEC_W(VEC_W), .EXC_VECTOR(EXC_VECTOR)) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_class(ins_class),
  .ins_ready(ins_ready), .err_det(err_det), .mode_exc(mode_exc),
  .issue_grant(issue_grant), .stall(stall), .exc_req(exc_req),
  .exc_vector(exc_vector), .err_n(err_n)
);

// File: tb/fp_err_gate_tb_top.sv
`timescale 1ns/1ps
module fp_err_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ins_valid = 1'b0;
  logic [1:0] ins_class = 2'b00;
  logic       err_det = 1'b0;
  logic       mode_exc = 1'b0;
  logic       ignore_n = 1'b1;
  logic       ins_ready, issue_grant, stall, exc_req, err_n;
  logic [7:0] exc_vector;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  bit m_pend = 0;
  bit m_ign_hist [$];

  always #2 clk = ~clk;

  fp_err_gate dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_class(ins_class),
    .ins_ready(ins_ready), .err_det(err_det), .mode_exc(mode_exc),
    .ignore_n(ignore_n), .issue_grant(issue_grant), .stall(stall),
    .exc_req(exc_req), .exc_vector(exc_vector), .err_n(err_n)
  );

  function automatic bit synced_ign();
    // value seen after two sampling edges; 1 until two samples exist
    if (m_ign_hist.size() < 2) return 1'b1;
    return m_ign_hist[m_ign_hist.size()-2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0;
      m_ign_hist.delete();
    end else begin
      if (err_det) m_pend = 1;
      else if (ins_valid && ins_class == 2'b10) m_pend = 0;
      m_ign_hist.push_back(ignore_n);
      if (m_ign_hist.size() > 4) void'(m_ign_hist.pop_front());
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, between the negedge drive and the next posedge
  always @(negedge clk) begin
    #1.5;
    if (rst_n) begin
      bit nonctl, hit, e_exc, e_stall, e_grant;
      nonctl  = !(ins_class == 2'b01 || ins_class == 2'b10);
      hit     = ins_valid && m_pend && nonctl;
      e_exc   = hit && mode_exc;
      e_stall = hit && !mode_exc && synced_ign();
      e_grant = ins_valid && !e_exc && !e_stall;
      cmp("issue_grant", issue_grant, e_grant);
      cmp("stall", stall, e_stall);
      cmp("exc_req", exc_req, e_exc);
      cmp("exc_vector", exc_vector, e_exc ? 16 : 0);
      cmp("ins_ready", ins_ready, e_grant || e_exc);
      cmp("err_n", err_n, !m_pend);
    end
  end

  task automatic drive(bit v, bit [1:0] c, bit e, bit m, bit ig);
    @(negedge clk);
    ins_valid = v; ins_class = c; err_det = e; mode_exc = m; ignore_n = ig;
  endtask

  task automatic idle(int n, bit m, bit ig);
    for (int i = 0; i < n; i++) drive(0, 2'b00, 0, m, ig);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset state observed during and just after reset
    repeat (3) @(negedge clk);
    #1;
    cmp("R1 err_n in reset", err_n, 1);
    cmp("R1 stall in reset", stall, 0);
    cmp("R1 grant in reset", issue_grant, 0);
    rst_n = 1'b1;
    idle(3, 0, 1);

    cur_req = "R10";
    for (int c = 0; c < 4; c++) drive(1, 2'(c), 0, 0, 1);
    for (int c = 0; c < 4; c++) drive(1, 2'(c), 0, 1, 1);

    cur_req = "R2";
    drive(0, 0, 1, 0, 1);
    idle(3, 0, 1);

    cur_req = "R3";
    drive(1, 2'b00, 0, 1, 1);
    drive(1, 2'b11, 0, 1, 0);
    idle(1, 1, 1);

    cur_req = "R6";
    drive(1, 2'b01, 0, 1, 1);
    drive(1, 2'b01, 0, 0, 1);
    idle(2, 0, 1);

    cur_req = "R5";
    for (int i = 0; i < 5; i++) drive(1, 2'b00, 0, 0, 1);
    for (int i = 0; i < 4; i++) drive(1, 2'b00, 0, 0, 0);

    cur_req = "R4";
    drive(1, 2'b11, 0, 0, 0);
    drive(1, 2'b00, 0, 0, 0);

    cur_req = "R7";
    drive(1, 2'b01, 0, 0, 1);
    idle(3, 0, 1);
    drive(1, 2'b00, 0, 0, 1);
    drive(1, 2'b10, 0, 0, 1);
    drive(1, 2'b00, 0, 0, 1);

    cur_req = "R8";
    drive(1, 2'b10, 1, 0, 1);
    drive(1, 2'b00, 0, 0, 1);
    drive(1, 2'b10, 0, 1, 1);
    drive(1, 2'b00, 0, 1, 1);

    cur_req = "R9";
    for (int i = 0; i < 400; i++) begin
      bit [1:0] c;
      c = 2'($urandom_range(0, 3));
      drive(($urandom_range(0, 3) != 0), c, ($urandom_range(0, 7) == 0),
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) != 0));
    end
    idle(2, 0, 1);
    finish_run();
  end
endmodule